// File: doc/BRIEF.md
# Leak-List Token Bucket Shaper

This block tracks a committed-rate token bucket for each egress scheduling element and shows each bucket as one eligibility bit. A downstream scheduler reads that bit. Each transmitted frame adds its size in bits to the bucket of its element. A frame's size can include the line overhead or leave it out, and this is chosen for each element. An element may send while its fill is below its burst allowance.

Buckets drain in groups. Every element belongs to one of a few leak groups. Each group has a period timer counted in nanoseconds. When a group's timer expires, a single walker starts at the group's head element and follows a next link stored with each element. The walker visits one element per clock and subtracts that element's rate from its bucket. A list ends at an element that links to itself. When several groups are due at once, they are walked one after another, and the lowest-numbered group goes first. A group whose previous walk has not finished when its next tick arrives raises a sticky overrun flag.

All settings arrive through a simple write port. This port covers group periods, group head pointers, element links, and the per-element rate, burst and accounting mode.

Top module: `llq_shaper`

## Requirements
- R1: After reset every `elig` bit and every `grp_err` bit is 0, every group period is 0, every head pointer is 0, and every element links to itself.
- R2: When `tx_valid` is high, the element `tx_elem` adds `tx_len`×8 bits to its fill if its mode field is non-zero. Mode 1 is data-rate accounting.
- R3: In mode 0 (line-rate accounting), a frame adds (`tx_len`+20)×8 bits, which covers preamble and inter-frame gap.
- R4: `elig[e]` is 1 while the fill of element e is strictly below burst×32768 bits, so burst 0 is never eligible. A shape write uses `cfg_kind`=3, with rate in `cfg_wdata[16:0]`, burst in `[22:17]` and mode in `[24:23]`.
- R5: Each walker visit subtracts the element's rate from its fill and saturates at 0. A frame and a visit in the same cycle add first and then subtract.
- R6: A period write (`cfg_kind`=0, `cfg_wdata[17:0]` in ns) restarts the group timer. After the write the group ticks every ceil(period/CLK_NS) cycles. A period of 0 produces no ticks.
- R7: A walk starts at the head pointer (`cfg_kind`=1, `cfg_wdata[15:0]`) and follows each element's link (`cfg_kind`=2, `cfg_wdata[15:0]`), one element per clock. It ends after it visits an element that links to itself or links beyond the last element.
- R8: Only one walk runs at a time. Among pending groups, the lowest index starts first.
- R9: `grp_err[g]` is set when group g ticks while its previous walk is still pending or running. The flag stays set until group g's head pointer is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Target: 0 period, 1 head pointer, 2 link, 3 shape |
| cfg_idx | input | 16 | Group or element index of the write |
| cfg_wdata | input | 25 | Write data, laid out per target |
| tx_valid | input | 1 | A frame was transmitted this cycle |
| tx_elem | input | IDX_W (3) | Element the frame belongs to |
| tx_len | input | LEN_W (14) | Frame length in bytes |
| elig | output | NUM_ELEM (8) | Per-element eligibility |
| grp_err | output | NUM_GRP (4) | Per-group sticky overrun flag |

## Verification
A frame or a shape write changes `elig` at the first rising edge that samples it. The bench drives stimulus after a falling edge and checks at the next falling edge. A leak lands two edges after the tick edge for the first element of a list, and one edge later for each further element. A tick comes ceil(period/4) edges after the period write. The bench therefore waits a fixed margin that falls inside one period and outside the next one. Priority between groups is checked by polling until the first eligibility change and then comparing both bits in that same sample.

// File: rtl/llq_pkg.sv
package llq_pkg;

    localparam int RATE_W         = 17;
    localparam int BURST_W        = 6;
    localparam int MODE_W         = 2;
    localparam int LINK_W         = 16;
    localparam int PERIOD_W       = 18;
    localparam int SHAPE_W        = RATE_W + BURST_W + MODE_W;
    localparam int BURST_SHIFT    = 15;   // 4096 bytes * 8 bits
    localparam int OVERHEAD_BYTES = 20;

    typedef enum logic [1:0] {
        CFG_PERIOD = 2'd0,
        CFG_FIRST  = 2'd1,
        CFG_LINK   = 2'd2,
        CFG_SHAPE  = 2'd3
    } cfg_kind_e;

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [BURST_W-1:0] burst;
        logic [RATE_W-1:0]  rate;
    } shape_t;

    function automatic shape_t unpack_shape(input logic [SHAPE_W-1:0] w);
        return shape_t'(w);
    endfunction

    function automatic logic is_line_mode(input shape_t s);
        return s.mode == '0;
    endfunction

endpackage

// File: rtl/llq_period_timer.sv
module llq_period_timer
    import llq_pkg::*;
#(
    parameter int CLK_NS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);
    localparam int ACC_W = PERIOD_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_step;

    assign acc_step = acc_q + ACC_W'(CLK_NS);
    assign tick     = (period != '0) && !restart && (acc_step >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (rst || restart || period == '0 || tick) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_step;
        end
    end
endmodule

// File: rtl/llq_walker.sv
module llq_walker
    import llq_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int NUM_GRP  = 4,
    localparam int IDX_W   = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
    localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_GRP-1:0]                tick,
    input  logic [NUM_GRP-1:0]                err_clr,
    input  logic [NUM_GRP-1:0][LINK_W-1:0]    first,
    input  logic [NUM_ELEM-1:0][LINK_W-1:0]   link,
    output logic                              leak_vld,
    output logic [IDX_W-1:0]                  leak_idx,
    output logic [NUM_GRP-1:0]                grp_err
);
    logic [NUM_GRP-1:0] pend_q;
    logic               busy_q;
    logic [LINK_W-1:0]  cur_q;
    logic [GRP_W-1:0]   cur_grp_q;

    logic               cur_ok;
    logic [LINK_W-1:0]  nxt;
    logic               at_end;
    logic               sel_vld;
    logic [GRP_W-1:0]   sel;

    assign cur_ok   = cur_q < LINK_W'(NUM_ELEM);
    assign nxt      = cur_ok ? link[cur_q[IDX_W-1:0]] : cur_q;
    assign at_end   = !cur_ok || (nxt == cur_q);
    assign leak_vld = busy_q && cur_ok;
    assign leak_idx = cur_q[IDX_W-1:0];

    // fixed priority: lowest pending group wins
    always_comb begin
        sel_vld = 1'b0;
        sel     = '0;
        for (int g = NUM_GRP - 1; g >= 0; g--) begin
            if (pend_q[g]) begin
                sel_vld = 1'b1;
                sel     = GRP_W'(g);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            busy_q    <= 1'b0;
            cur_q     <= '0;
            cur_grp_q <= '0;
            grp_err   <= '0;
        end else begin
            for (int g = 0; g < NUM_GRP; g++) begin
                grp_err[g] <= (grp_err[g] && !err_clr[g]) ||
                              (tick[g] && (pend_q[g] ||
                               (busy_q && cur_grp_q == GRP_W'(g))));
                if (tick[g]) begin
                    pend_q[g] <= 1'b1;
                end else if (!busy_q && sel_vld && sel == GRP_W'(g)) begin
                    pend_q[g] <= 1'b0;
                end
            end
            if (!busy_q) begin
                if (sel_vld) begin
                    busy_q    <= 1'b1;
                    cur_q     <= first[sel];
                    cur_grp_q <= sel;
                end
            end else if (at_end) begin
                busy_q <= 1'b0;
            end else begin
                cur_q <= nxt;
            end
        end
    end
endmodule

// File: rtl/llq_bucket.sv
module llq_bucket
    import llq_pkg::*;
#(
    parameter int LEN_W  = 14,
    parameter int FILL_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  shape_t           shape,
    input  logic             tx_en,
    input  logic [LEN_W-1:0] tx_len,
    input  logic             leak_en,
    output logic             elig
);
    localparam int BYTES_W = LEN_W + 1;

    logic [FILL_W-1:0] fill_q;
    logic [BYTES_W-1:0] bytes;
    logic [FILL_W-1:0] add_bits;
    logic [FILL_W:0]   sum;
    logic [FILL_W-1:0] sat;
    logic [FILL_W-1:0] rate_ext;
    logic [FILL_W-1:0] thresh;

    assign bytes    = BYTES_W'(tx_len) +
                      (is_line_mode(shape) ? BYTES_W'(OVERHEAD_BYTES) : '0);
    assign add_bits = tx_en ? FILL_W'({bytes, 3'b000}) : '0;
    assign sum      = {1'b0, fill_q} + {1'b0, add_bits};
    assign sat      = sum[FILL_W] ? '1 : sum[FILL_W-1:0];
    assign rate_ext = FILL_W'(shape.rate);
    assign thresh   = FILL_W'({shape.burst, {BURST_SHIFT{1'b0}}});
    assign elig     = fill_q < thresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (leak_en) begin
            fill_q <= (sat > rate_ext) ? (sat - rate_ext) : '0;
        end else if (tx_en) begin
            fill_q <= sat;
        end
    end
endmodule

// File: rtl/llq_shaper.sv
module llq_shaper
    import llq_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int NUM_GRP  = 4,
    parameter int CLK_NS   = 4,
    parameter int LEN_W    = 14,
    parameter int FILL_W   = 24,
    localparam int IDX_W   = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_kind,
    input  logic [LINK_W-1:0]   cfg_idx,
    input  logic [SHAPE_W-1:0]  cfg_wdata,
    input  logic                tx_valid,
    input  logic [IDX_W-1:0]    tx_elem,
    input  logic [LEN_W-1:0]    tx_len,
    output logic [NUM_ELEM-1:0] elig,
    output logic [NUM_GRP-1:0]  grp_err
);
    cfg_kind_e kind;
    assign kind = cfg_kind_e'(cfg_kind);

    logic [NUM_GRP-1:0][PERIOD_W-1:0] period_q;
    logic [NUM_GRP-1:0][LINK_W-1:0]   first_q;
    logic [NUM_ELEM-1:0][LINK_W-1:0]  link_q;
    shape_t [NUM_ELEM-1:0]            shape_q;

    logic [NUM_GRP-1:0]  wr_period;
    logic [NUM_GRP-1:0]  wr_first;
    logic [NUM_ELEM-1:0] wr_link;
    logic [NUM_ELEM-1:0] wr_shape;

    logic [NUM_GRP-1:0]  tick_vec;
    logic [NUM_GRP-1:0]  period_zero_vec;
    logic [NUM_ELEM-1:0] leak_en_vec;
    logic                leak_vld;
    logic [IDX_W-1:0]    leak_idx;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^cfg_wdata[SHAPE_W-1:PERIOD_W];

    genvar g, e;
    generate
        for (g = 0; g < NUM_GRP; g++) begin : gen_grp
            assign wr_period[g]       = cfg_we && kind == CFG_PERIOD && cfg_idx == LINK_W'(g);
            assign wr_first[g]        = cfg_we && kind == CFG_FIRST  && cfg_idx == LINK_W'(g);
            assign period_zero_vec[g] = period_q[g] == '0;

            always_ff @(posedge clk) begin
                if (rst) begin
                    period_q[g] <= '0;
                    first_q[g]  <= '0;
                end else begin
                    if (wr_period[g]) period_q[g] <= cfg_wdata[PERIOD_W-1:0];
                    if (wr_first[g])  first_q[g]  <= cfg_wdata[LINK_W-1:0];
                end
            end

            llq_period_timer #(.CLK_NS(CLK_NS)) timer_i (
                .clk     (clk),
                .rst     (rst),
                .restart (wr_period[g]),
                .period  (period_q[g]),
                .tick    (tick_vec[g])
            );
        end

        for (e = 0; e < NUM_ELEM; e++) begin : gen_elem
            assign wr_link[e]     = cfg_we && kind == CFG_LINK  && cfg_idx == LINK_W'(e);
            assign wr_shape[e]    = cfg_we && kind == CFG_SHAPE && cfg_idx == LINK_W'(e);
            assign leak_en_vec[e] = leak_vld && leak_idx == IDX_W'(e);

            always_ff @(posedge clk) begin
                if (rst) begin
                    link_q[e]  <= LINK_W'(e);
                    shape_q[e] <= '0;
                end else begin
                    if (wr_link[e])  link_q[e]  <= cfg_wdata[LINK_W-1:0];
                    if (wr_shape[e]) shape_q[e] <= unpack_shape(cfg_wdata);
                end
            end

            llq_bucket #(.LEN_W(LEN_W), .FILL_W(FILL_W)) bucket_i (
                .clk     (clk),
                .rst     (rst),
                .shape   (shape_q[e]),
                .tx_en   (tx_valid && tx_elem == IDX_W'(e)),
                .tx_len  (tx_len),
                .leak_en (leak_en_vec[e]),
                .elig    (elig[e])
            );
        end
    endgenerate

    llq_walker #(.NUM_ELEM(NUM_ELEM), .NUM_GRP(NUM_GRP)) walker_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_vec),
        .err_clr  (wr_first),
        .first    (first_q),
        .link     (link_q),
        .leak_vld (leak_vld),
        .leak_idx (leak_idx),
        .grp_err  (grp_err)
    );
endmodule

// File: rtl/llq_shaper_chk.sv
module llq_shaper_chk #(
    parameter int NUM_ELEM = 8,
    parameter int NUM_GRP  = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_we,
    input logic [1:0]          cfg_kind,
    input logic                tx_valid,
    input logic [NUM_ELEM-1:0] elig,
    input logic [NUM_GRP-1:0]  grp_err,
    input logic [NUM_GRP-1:0]  tick_vec,
    input logic [NUM_GRP-1:0]  period_zero_vec,
    input logic [NUM_ELEM-1:0] leak_en_vec
);
    // R1: outputs are quiet right after a reset cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (elig == '0 && grp_err == '0));

    // R4: an element only loses eligibility after a frame or a config write
    p_no_spurious_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (!tx_valid && !cfg_we) |=> (($past(elig) & ~elig) == '0));

    // R6: a group with period zero never ticks
    p_zero_period_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (tick_vec & period_zero_vec) == '0);

    // R7: the walker drains at most one element per clock
    p_one_leak_per_clk_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(leak_en_vec));

    // R9: overrun flags stay set until a head pointer write
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_kind == 2'd1) |=> ((grp_err & $past(grp_err)) == $past(grp_err)));
endmodule

bind llq_shaper llq_shaper_chk #(.NUM_ELEM(NUM_ELEM), .NUM_GRP(NUM_GRP)) chk_i (
    .clk             (clk),
    .rst             (rst),
    .cfg_we          (cfg_we),
    .cfg_kind        (cfg_kind),
    .tx_valid        (tx_valid),
    .elig            (elig),
    .grp_err         (grp_err),
    .tick_vec        (tick_vec),
    .period_zero_vec (period_zero_vec),
    .leak_en_vec     (leak_en_vec)
);

// File: tb/llq_shaper_tb_top.sv
module llq_shaper_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [15:0] cfg_idx = '0;
    logic [24:0] cfg_wdata = '0;
    logic        tx_valid = 1'b0;
    logic [2:0]  tx_elem = '0;
    logic [13:0] tx_len = '0;
    logic [7:0]  elig;
    logic [3:0]  grp_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    llq_shaper dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .tx_valid(tx_valid),
        .tx_elem(tx_elem), .tx_len(tx_len), .elig(elig), .grp_err(grp_err)
    );

    typedef struct packed {
        logic [2:0]  elem;
        logic [1:0]  mode;
        logic [5:0]  burst;
        logic [13:0] len;
        logic        exp;
    } vec_t;

    // accounting / threshold vectors, one fresh element each, no leaks
    localparam vec_t VECS [6] = '{
        '{3'd2, 2'd1, 6'd1, 14'd4096, 1'b0},  // R2 data: 32768 bits = limit
        '{3'd3, 2'd1, 6'd1, 14'd4095, 1'b1},  // R2 data: 32760 bits
        '{3'd4, 2'd0, 6'd1, 14'd4076, 1'b0},  // R3 line: (4076+20)*8 = 32768
        '{3'd5, 2'd0, 6'd1, 14'd4075, 1'b1},  // R3 line: 32760
        '{3'd6, 2'd1, 6'd2, 14'd8191, 1'b1},  // R4 burst 2: 65528 < 65536
        '{3'd7, 2'd1, 6'd0, 14'd1,    1'b0}   // R4 burst 0 never eligible
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic [1:0] kind, input int idx, input logic [24:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind; cfg_idx = 16'(idx); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input int elem, input int len);
        @(negedge clk);
        tx_valid = 1'b1; tx_elem = 3'(elem); tx_len = 14'(len);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    function automatic logic [24:0] shp(input logic [1:0] m, input logic [5:0] b, input int r);
        return {m, b, 17'(r)};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 elig", 32'(elig), 32'h0);
        check("R1 grp_err", 32'(grp_err), 32'h0);

        // table of accounting vectors
        for (int i = 0; i < 6; i++) begin
            cfg_write(2'd3, int'(VECS[i].elem), shp(VECS[i].mode, VECS[i].burst, 0));
            send(int'(VECS[i].elem), int'(VECS[i].len));
            check(VECS[i].mode == 2'd0 ? "R3" : (VECS[i].burst != 6'd1 ? "R4" : "R2"),
                  32'(elig[VECS[i].elem]), 32'(VECS[i].exp));
        end

        // R5: one leak of rate 1 frees a full bucket, then saturation at zero
        do_reset();
        cfg_write(2'd3, 0, shp(2'd1, 6'd1, 1));
        send(0, 4096);
        check("R4 full bucket", 32'(elig[0]), 32'h0);
        cfg_write(2'd0, 0, 25'd400);
        wait_cyc(110);
        check("R5 single leak", 32'(elig[0]), 32'h1);
        cfg_write(2'd3, 0, shp(2'd1, 6'd1, 100000));
        wait_cyc(120);
        cfg_write(2'd0, 0, 25'd0);
        send(0, 4095);
        check("R5 saturated at zero", 32'(elig[0]), 32'h1);
        send(0, 1);
        check("R4 limit reached", 32'(elig[0]), 32'h0);

        // R6: zero period never drains
        do_reset();
        cfg_write(2'd3, 1, shp(2'd1, 6'd1, 5));
        cfg_write(2'd1, 1, 25'd1);
        send(1, 4096);
        wait_cyc(300);
        check("R6 zero period", 32'(elig[1]), 32'h0);

        // R7: list 2 -> 0 -> 1 (self); element 3 outside the list
        do_reset();
        for (int e = 0; e < 4; e++) begin
            cfg_write(2'd3, e, shp(2'd1, 6'd1, 1));
            send(e, 4096);
        end
        cfg_write(2'd2, 2, 25'd0);
        cfg_write(2'd2, 0, 25'd1);
        cfg_write(2'd1, 2, 25'd2);
        cfg_write(2'd0, 2, 25'd400);
        wait_cyc(150);
        check("R7 list walk", 32'(elig[3:0]), 32'h7);
        check("R9 no overrun", 32'(grp_err), 32'h0);

        // R8: groups 0 and 1 tick on the same edge; group 0 drains first
        do_reset();
        cfg_write(2'd3, 0, shp(2'd1, 6'd1, 1));
        cfg_write(2'd3, 1, shp(2'd1, 6'd1, 1));
        send(0, 4096);
        send(1, 4096);
        cfg_write(2'd1, 1, 25'd1);
        cfg_write(2'd0, 1, 25'd400);
        cfg_write(2'd0, 0, 25'd392);
        for (int k = 0; k < 300; k++) begin
            if (elig[1:0] != 2'b00) break;
            @(negedge clk);
        end
        check("R8 lowest group first", 32'(elig[1:0]), 32'h1);
        wait_cyc(3);
        check("R8 second group follows", 32'(elig[1:0]), 32'h3);

        // R9: four-element list with a two-cycle period overruns
        do_reset();
        cfg_write(2'd2, 4, 25'd5);
        cfg_write(2'd2, 5, 25'd6);
        cfg_write(2'd2, 6, 25'd7);
        cfg_write(2'd1, 3, 25'd4);
        cfg_write(2'd0, 3, 25'd8);
        wait_cyc(20);
        check("R9 overrun set", 32'(grp_err), 32'h8);
        cfg_write(2'd0, 3, 25'd0);
        wait_cyc(10);
        check("R9 overrun sticky", 32'(grp_err), 32'h8);
        cfg_write(2'd1, 3, 25'd4);
        check("R9 cleared by head write", 32'(grp_err), 32'h0);

        finish_run();
    end
endmodule